// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides when a new group of threads (a thread block) offered by a work distributor may become resident. A block needs three things at the same time: a contiguous range of the register file large enough for every one of its threads, a contiguous range of shared memory, and room under the cap on resident threads. It also needs one of a small number of block slots. When all of these are available, the request is accepted in the cycle it is offered. The grant carries the slot number and the base offsets of the two ranges.

Resources stay with a block until a completion notice naming its slot arrives. There is no eviction. The released space can be granted again from the next cycle onward. Registers and shared memory are tracked as bitmaps of fixed-size allocation units, and each is searched first-fit for the lowest free run that is long enough. A request that could not fit even into an empty multiprocessor is consumed at once with an error flag, so it does not stall forever.

Top module: `blk_admit`

## Requirements
- R1: After reset no slot is resident and every resource is free. With `req_valid` low, `req_ready` and `req_err` are low.
- R2: A request is accepted (`req_ready`=1, `req_err`=0, both combinational in the cycle `req_valid` is high) only if register space, shared memory, thread room and a slot are all available. Otherwise it stalls with `req_ready`=0 and `req_err`=0.
- R3: Register demand is `req_threads`×`req_rpt`, rounded up to units of 512 registers (32 units). The grant takes the lowest-numbered contiguous run of free units, and `reg_base` = first unit × 512.
- R4: Shared-memory demand is `req_smem` bytes, rounded up to units of 512 bytes (32 units). The lowest free contiguous run is granted, and `smem_base` = first unit × 512.
- R5: The sum of thread counts over resident blocks never exceeds 1024. A request that would pass this limit stalls.
- R6: `grant_slot` is the lowest-numbered free slot among 8. With 8 blocks resident, every request stalls.
- R7: A `done_valid` pulse for a resident slot frees that slot, its two ranges and its threads at the clock edge. A request in that same cycle still sees the old state. The space is grantable from the next cycle.
- R8: A `done_valid` pulse naming a slot that is not resident has no effect, even if the slot's stale range is now owned by another block.
- R9: A request with 0 threads, more than 1024 threads, more than 16384 registers or more than 16384 shared bytes is answered with `req_ready`=1 and `req_err`=1 in the same cycle, and nothing is allocated.
- R10: A demand of zero registers or zero shared bytes consumes no units, and its base reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block request present |
| req_threads | input | 11 | Threads in the requested block |
| req_rpt | input | 8 | Registers needed per thread |
| req_smem | input | 15 | Shared-memory bytes needed by the block |
| req_ready | output | 1 | Request consumed this cycle (granted or refused) |
| req_err | output | 1 | Request refused: it can never fit |
| grant_slot | output | 3 | Slot assigned to the granted block |
| reg_base | output | 14 | First register of the granted register range |
| smem_base | output | 14 | First byte of the granted shared-memory range |
| done_valid | input | 1 | Completion pulse for a resident block |
| done_slot | input | 3 | Slot of the completing block |

## Verification
Some properties are checked by assertions on every cycle:
- the resident thread count never passes its cap;
- a newly taken unit range never overlaps units already in use;
- a released range was fully in use;
- a grant always lands in a free slot, which is resident on the next cycle;
- a completed slot is idle on the next cycle.

Other behaviour can only be shown by the directed scenarios:
- first-fit placement into a hole left by an earlier completion, and the rounding of demands to units;
- that a request in the same cycle as a completion still stalls;
- that a completion on an idle slot leaves another block's space alone;
- that impossible requests are refused instead of stalling.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  localparam int unsigned DEF_REG_TOTAL   = 16384;
  localparam int unsigned DEF_REG_UNIT    = 512;
  localparam int unsigned DEF_SMEM_TOTAL  = 16384;
  localparam int unsigned DEF_SMEM_UNIT   = 512;
  localparam int unsigned DEF_MAX_THREADS = 1024;
  localparam int unsigned DEF_SLOTS       = 8;
  localparam int unsigned DEF_RPT_W       = 8;
endpackage

// File: rtl/blk_unit_pool.sv
module blk_unit_pool #(
  parameter int unsigned UNITS = 32,
  localparam int unsigned IDX_W = $clog2(UNITS),
  localparam int unsigned CNT_W = $clog2(UNITS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] need,
  input  logic             take,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_start,
  input  logic [CNT_W-1:0] rel_len,
  output logic             fit,
  output logic [IDX_W-1:0] start
);
  logic [UNITS-1:0] used_q, used_d, take_mask, rel_mask;

  // first-fit search: lowest start whose window is entirely free
  always_comb begin
    fit   = 1'b0;
    start = '0;
    for (int s = UNITS - 1; s >= 0; s--) begin
      logic ok;
      ok = (s + int'(need)) <= int'(UNITS);
      for (int i = 0; i < int'(UNITS); i++) begin
        if (used_q[i] && i >= s && i < s + int'(need)) ok = 1'b0;
      end
      if (ok) begin
        fit   = 1'b1;
        start = IDX_W'(s);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < int'(UNITS); i++) begin
      take_mask[i] = (i >= int'(start)) && (i < int'(start) + int'(need));
      rel_mask[i]  = (i >= int'(rel_start)) && (i < int'(rel_start) + int'(rel_len));
    end
    used_d = used_q;
    if (rel_en) used_d = used_d & ~rel_mask;
    if (take)   used_d = used_d | take_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              used_q <= '0;
    else if (take || rel_en) used_q <= used_d;
  end

  // R3 R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((used_q & take_mask) == '0));
  // R7
  rel_in_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> ((used_q & rel_mask) == rel_mask));
endmodule

// File: rtl/blk_slot_table.sv
module blk_slot_table #(
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned RIDX_W      = 5,
  parameter int unsigned SIDX_W      = 5,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned THR_W  = $clog2(MAX_THREADS) + 1,
  localparam int unsigned RCNT_W = RIDX_W + 1,
  localparam int unsigned SCNT_W = SIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [THR_W-1:0]  take_thr,
  input  logic [RIDX_W-1:0] take_rstart,
  input  logic [RCNT_W-1:0] take_rlen,
  input  logic [SIDX_W-1:0] take_sstart,
  input  logic [SCNT_W-1:0] take_slen,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  output logic              slot_avail,
  output logic [SLOT_W-1:0] free_slot,
  output logic [THR_W-1:0]  thr_used,
  output logic              rel_en,
  output logic [RIDX_W-1:0] rel_rstart,
  output logic [RCNT_W-1:0] rel_rlen,
  output logic [SIDX_W-1:0] rel_sstart,
  output logic [SCNT_W-1:0] rel_slen
);
  logic [SLOTS-1:0]  busy_q, busy_d;
  logic [THR_W-1:0]  thr_q  [SLOTS];
  logic [RIDX_W-1:0] rs_q   [SLOTS];
  logic [RCNT_W-1:0] rl_q   [SLOTS];
  logic [SIDX_W-1:0] ss_q   [SLOTS];
  logic [SCNT_W-1:0] sl_q   [SLOTS];
  logic [THR_W-1:0]  used_q, used_d;

  always_comb begin
    slot_avail = 1'b0;
    free_slot  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        slot_avail = 1'b1;
        free_slot  = SLOT_W'(i);
      end
    end
  end

  assign rel_en     = done_valid && busy_q[done_slot];
  assign rel_rstart = rs_q[done_slot];
  assign rel_rlen   = rl_q[done_slot];
  assign rel_sstart = ss_q[done_slot];
  assign rel_slen   = sl_q[done_slot];
  assign thr_used   = used_q;

  always_comb begin
    busy_d = busy_q;
    used_d = used_q;
    if (rel_en) begin
      busy_d[done_slot] = 1'b0;
      used_d = used_d - thr_q[done_slot];
    end
    if (take) begin
      busy_d[free_slot] = 1'b1;
      used_d = used_d + take_thr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      used_q <= '0;
    end else if (take || rel_en) begin
      busy_q <= busy_d;
      used_q <= used_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_rec
    logic wr;
    assign wr = take && (free_slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[g] <= '0;
        rs_q[g]  <= '0;
        rl_q[g]  <= '0;
        ss_q[g]  <= '0;
        sl_q[g]  <= '0;
      end else if (wr) begin
        thr_q[g] <= take_thr;
        rs_q[g]  <= take_rstart;
        rl_q[g]  <= take_rlen;
        ss_q[g]  <= take_sstart;
        sl_q[g]  <= take_slen;
      end
    end
  end

  // R5
  thread_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= THR_W'(MAX_THREADS));
  // R6
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> slot_avail);
  // R6
  grant_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_q[$past(free_slot)]);
  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> !busy_q[$past(done_slot)]);
endmodule

// File: rtl/blk_admit.sv
module blk_admit
  import blk_admit_pkg::*;
#(
  parameter int unsigned REG_TOTAL   = DEF_REG_TOTAL,
  parameter int unsigned REG_UNIT    = DEF_REG_UNIT,
  parameter int unsigned SMEM_TOTAL  = DEF_SMEM_TOTAL,
  parameter int unsigned SMEM_UNIT   = DEF_SMEM_UNIT,
  parameter int unsigned MAX_THREADS = DEF_MAX_THREADS,
  parameter int unsigned SLOTS       = DEF_SLOTS,
  parameter int unsigned RPT_W       = DEF_RPT_W,
  localparam int unsigned THR_W   = $clog2(MAX_THREADS) + 1,
  localparam int unsigned SMEM_W  = $clog2(SMEM_TOTAL) + 1,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned RBASE_W = $clog2(REG_TOTAL),
  localparam int unsigned SBASE_W = $clog2(SMEM_TOTAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [THR_W-1:0]   req_threads,
  input  logic [RPT_W-1:0]   req_rpt,
  input  logic [SMEM_W-1:0]  req_smem,
  output logic               req_ready,
  output logic               req_err,
  output logic [SLOT_W-1:0]  grant_slot,
  output logic [RBASE_W-1:0] reg_base,
  output logic [SBASE_W-1:0] smem_base,
  input  logic               done_valid,
  input  logic [SLOT_W-1:0]  done_slot
);
  localparam int unsigned R_UNITS = REG_TOTAL / REG_UNIT;
  localparam int unsigned S_UNITS = SMEM_TOTAL / SMEM_UNIT;
  localparam int unsigned RIDX_W  = $clog2(R_UNITS);
  localparam int unsigned SIDX_W  = $clog2(S_UNITS);
  localparam int unsigned R_SH    = $clog2(REG_UNIT);
  localparam int unsigned S_SH    = $clog2(SMEM_UNIT);
  localparam int unsigned NEED_W  = THR_W + RPT_W;

  logic [NEED_W-1:0] reg_need;
  logic [NEED_W:0]   reg_sum;
  logic [SMEM_W:0]   smem_sum;
  logic [RIDX_W:0]   reg_units;
  logic [SIDX_W:0]   smem_units;
  logic              never, fits_all, take, thr_room;
  logic              r_fit, s_fit, slot_avail;
  logic [RIDX_W-1:0] r_start;
  logic [SIDX_W-1:0] s_start;
  logic [THR_W-1:0]  thr_used;
  logic              rel_en;
  logic [RIDX_W-1:0] rel_rstart;
  logic [RIDX_W:0]   rel_rlen;
  logic [SIDX_W-1:0] rel_sstart;
  logic [SIDX_W:0]   rel_slen;

  // demand in allocation units, rounded up
  assign reg_need   = {{RPT_W{1'b0}}, req_threads} * {{THR_W{1'b0}}, req_rpt};
  assign reg_sum    = {1'b0, reg_need} + (NEED_W+1)'(REG_UNIT - 1);
  assign smem_sum   = {1'b0, req_smem} + (SMEM_W+1)'(SMEM_UNIT - 1);
  assign reg_units  = (RIDX_W+1)'(reg_sum >> R_SH);
  assign smem_units = (SIDX_W+1)'(smem_sum >> S_SH);

  assign never = (req_threads == '0) || (req_threads > THR_W'(MAX_THREADS)) ||
                 (reg_need > NEED_W'(REG_TOTAL)) || (req_smem > SMEM_W'(SMEM_TOTAL));
  assign thr_room = ({1'b0, thr_used} + {1'b0, req_threads}) <= (THR_W+1)'(MAX_THREADS);
  assign fits_all = r_fit && s_fit && slot_avail && thr_room;
  assign take     = req_valid && !never && fits_all;

  assign req_ready = req_valid && (never || fits_all);
  assign req_err   = req_valid && never;
  assign reg_base  = RBASE_W'(r_start) << R_SH;
  assign smem_base = SBASE_W'(s_start) << S_SH;

  blk_unit_pool #(.UNITS(R_UNITS)) u_reg_pool (
    .clk, .rst_n, .need(reg_units), .take, .rel_en,
    .rel_start(rel_rstart), .rel_len(rel_rlen), .fit(r_fit), .start(r_start)
  );

  blk_unit_pool #(.UNITS(S_UNITS)) u_smem_pool (
    .clk, .rst_n, .need(smem_units), .take, .rel_en,
    .rel_start(rel_sstart), .rel_len(rel_slen), .fit(s_fit), .start(s_start)
  );

  blk_slot_table #(
    .SLOTS(SLOTS), .MAX_THREADS(MAX_THREADS), .RIDX_W(RIDX_W), .SIDX_W(SIDX_W)
  ) u_slots (
    .clk, .rst_n, .take, .take_thr(req_threads),
    .take_rstart(r_start), .take_rlen(reg_units),
    .take_sstart(s_start), .take_slen(smem_units),
    .done_valid, .done_slot, .slot_avail, .free_slot(grant_slot), .thr_used,
    .rel_en, .rel_rstart, .rel_rlen, .rel_sstart, .rel_slen
  );
endmodule

// File: tb/blk_admit_tb.sv
`timescale 1ns/1ps
module blk_admit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, done_valid;
  logic [10:0] req_threads;
  logic [7:0]  req_rpt;
  logic [14:0] req_smem;
  logic [2:0]  done_slot, grant_slot;
  logic        req_ready, req_err;
  logic [13:0] reg_base, smem_base;
  int checks = 0, errors = 0;
  logic o_rdy, o_err;
  int   o_slot, o_rb, o_sb;

  always #4 clk = ~clk;

  blk_admit u_dut (
    .clk, .rst_n, .req_valid, .req_threads, .req_rpt, .req_smem,
    .req_ready, .req_err, .grant_slot, .reg_base, .smem_base,
    .done_valid, .done_slot
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample before the posedge, release after it
  task automatic cyc(input logic v, input int thr, input int rpt, input int sm,
                     input logic dv, input int ds);
    @(negedge clk);
    req_valid = v; req_threads = 11'(thr); req_rpt = 8'(rpt); req_smem = 15'(sm);
    done_valid = dv; done_slot = 3'(ds);
    #1;
    o_rdy = req_ready; o_err = req_err;
    o_slot = int'(grant_slot); o_rb = int'(reg_base); o_sb = int'(smem_base);
    @(posedge clk); #1;
    req_valid = 1'b0; done_valid = 1'b0;
  endtask

  task automatic req(int thr, int rpt, int sm); cyc(1'b1, thr, rpt, sm, 1'b0, 0); endtask
  task automatic fin(int s); cyc(1'b0, 0, 0, 0, 1'b1, s); endtask

  task automatic expect_grant(string tag, int slot, int rb, int sb);
    chk({tag, " ready"}, o_rdy, 1);
    chk({tag, " err"}, o_err, 0);
    chk({tag, " slot"}, o_slot, slot);
    chk({tag, " reg_base"}, o_rb, rb);
    chk({tag, " smem_base"}, o_sb, sb);
  endtask

  task automatic expect_stall(string tag);
    chk({tag, " ready"}, o_rdy, 0);
    chk({tag, " err"}, o_err, 0);
  endtask

  task automatic t_reset;
    cyc(1'b0, 0, 0, 0, 1'b0, 0);
    chk("R1 idle ready", o_rdy, 0);
    chk("R1 idle err", o_err, 0);
    req(1024, 16, 16384);
    expect_grant("R1 full block", 0, 0, 0);
    fin(0);
  endtask

  task automatic t_first_fit;
    req(256, 8, 1000);  expect_grant("R3 A", 0, 0, 0);
    req(128, 10, 512);  expect_grant("R3 B rounding", 1, 2048, 1024);
    req(64, 1, 0);      expect_grant("R10 zero smem", 2, 3584, 0);
    req(32, 0, 1);      expect_grant("R4 zero regs", 3, 0, 1536);
    fin(1);
    req(64, 16, 512);   expect_grant("R7 hole reuse", 1, 2048, 1024);
    for (int s = 0; s < 4; s++) fin(s);
  endtask

  task automatic t_reg_stall;
    req(1024, 16, 0);   expect_grant("R2 regs full", 0, 0, 0);
    req(32, 1, 0);      expect_stall("R2 regs stall");
    cyc(1'b1, 32, 1, 0, 1'b1, 0);
    expect_stall("R7 same-cycle stall");
    req(32, 1, 0);      expect_grant("R7 next-cycle grant", 0, 0, 0);
    fin(0);
  endtask

  task automatic t_threads;
    req(1024, 0, 0);    expect_grant("R5 full threads", 0, 0, 0);
    req(1, 0, 0);       expect_stall("R5 thread cap stall");
    fin(0);
    req(1, 0, 0);       expect_grant("R5 after free", 0, 0, 0);
    fin(0);
  endtask

  task automatic t_smem;
    req(32, 0, 16384);  expect_grant("R4 smem full", 0, 0, 0);
    req(32, 0, 1);      expect_stall("R2 smem stall");
    fin(0);
    req(32, 0, 1);      expect_grant("R4 after free", 0, 0, 0);
    fin(0);
  endtask

  task automatic t_slots;
    for (int i = 0; i < 8; i++) begin
      req(1, 0, 0);
      chk("R6 slot order", o_slot, i);
      chk("R6 slot ready", o_rdy, 1);
    end
    req(1, 0, 0);       expect_stall("R6 all slots busy");
    fin(3);
    req(1, 0, 0);       expect_grant("R6 lowest free", 3, 0, 0);
    for (int i = 0; i < 8; i++) fin(i);
  endtask

  task automatic t_idle_done;
    req(32, 64, 0);     expect_grant("R8 P", 0, 0, 0);
    req(32, 64, 0);     expect_grant("R8 Q", 1, 2048, 0);
    fin(0);
    fin(1);
    req(32, 128, 0);    expect_grant("R8 R", 0, 0, 0);
    fin(1);
    req(32, 16, 0);     expect_grant("R8 idle done ignored", 1, 4096, 0);
    fin(0);
    fin(1);
  endtask

  task automatic t_never;
    req(0, 1, 0);
    chk("R9 zero threads ready", o_rdy, 1); chk("R9 zero threads err", o_err, 1);
    req(1025, 0, 0);
    chk("R9 too many threads ready", o_rdy, 1); chk("R9 too many threads err", o_err, 1);
    req(1024, 17, 0);
    chk("R9 too many regs ready", o_rdy, 1); chk("R9 too many regs err", o_err, 1);
    req(1, 0, 16385);
    chk("R9 too much smem ready", o_rdy, 1); chk("R9 too much smem err", o_err, 1);
    req(1024, 16, 16384);
    expect_grant("R9 nothing allocated", 0, 0, 0);
    fin(0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
    req_threads = '0; req_rpt = '0; req_smem = '0; done_slot = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_first_fit;
    t_reg_stall;
    t_threads;
    t_smem;
    t_slots;
    t_idle_done;
    t_never;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule